// File: doc/BRIEF.md
# Legacy INTx Interrupt Status and Mask Register

This block gathers the four level-sensitive legacy interrupt lines of a PCI host bridge (A, B, C, D) into one 32-bit control word. The word holds a pending bit and an enable bit for each line, enables for eight bus-error interrupt sources, and a field of plain read/write arbitration priority flags. The block drives one registered interrupt output towards a parent interrupt controller. The output is high while any pending line is enabled or any latched error flag is enabled.

Software reaches the block through a simple 32-bit register port with byte-lane enables. Pending bits are acknowledged by writing ones to them. Because pending bits, line enables and error enables all share one word, a read-modify-write sequence must put zeros in the pending field so that it does not acknowledge other lines. Error events arrive as single-cycle pulses. Each pulse is held in a sticky flag, and the flags sit in a second register that is also cleared by writing ones. All lines are level-triggered. A line that is still asserted cannot be acknowledged away.

Top module: `intx_irq_unit`

## Requirements
- R1: After reset, both registers read zero (no pending bits, no flags, all lines and error sources disabled, priority flags zero) and `irq_out` is low.
- R2: While line input `intx_lvl[i]` is high at a clock edge, pending bit 28+i of the control word (line A at bit 28, D at bit 31) is set from that edge onward, whatever its enable. A pending bit never sets while its line is low.
- R3: Writing the control word (offset 0x4C) with byte lane 3 enabled clears pending bit 28+i where the written bit is 1 and the line is low. A written 0 leaves the pending bit unchanged.
- R4: Acknowledging a pending bit while its line input is still high leaves the bit set.
- R5: Control bits 25:22 are read/write line enables (line A at bit 22, 1 = enabled). `irq_out` is high one cycle after any pending bit is set together with its enable, and low one cycle after no enabled source remains.
- R6: A one-cycle pulse on `err_evt[k]` sets sticky flag k, which reads at bit k of the error register (offset 0x60). Writing 1 to bit k there (lane 0 enabled) clears the flag. A pulse in the same cycle as the clear keeps the flag set.
- R7: Error enables for events 0..5 sit at control bits 16..21, and those for events 6 and 7 at bits 26 and 27. An enabled set flag drives `irq_out` high one cycle later.
- R8: Control bits 14:8 are read/write priority flags. Bits 15 and 7:0 of the control word, bits 31:8 of the error register, and every other offset all read as zero.
- R9: Only bytes whose `reg_be` bit is 1 are written. A write of 0xF000_0000 with lanes 3 and 2 enabled clears every pending bit whose line is low, and disables all lines and all error sources in one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| intx_lvl | input | 4 | Level-sensitive legacy interrupt lines, bit 0 = line A |
| err_evt | input | 8 | Single-cycle bus-error event pulses |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 4 | Byte-lane enables for a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Registered cascaded interrupt to the parent controller |

## Verification
Every cycle, the assertions check the per-line capture rules: a high line sets its pending bit, a low and clear line stays clear, an acknowledge drops the bit only while the line is low, and an acknowledge under a high line holds it. They also check that error flags stick and clear, that enables hold without a write, and that the output follows any enabled source one cycle later. Only the bench scenarios can show the bit positions as software sees them, lane masking on partial writes, the halfword mask-and-clear access, reserved bits reading zero, and the pending field surviving a write of zeros.

// File: rtl/intx_pkg.sv
package intx_pkg;

  localparam int REG_W    = 32;
  localparam int N_LINES  = 4;
  localparam int N_ERRS   = 8;
  localparam int PEND_LSB = 28;
  localparam int ENA_LSB  = 22;
  localparam int PRIO_LSB = 8;
  localparam int PRIO_W   = 7;

  // Bit position of the enable for error event k inside the control word
  function automatic int err_en_pos(input int k);
    return (k < 6) ? (16 + k) : (20 + k);
  endfunction

  // Expand byte-lane enables into a per-bit write mask
  function automatic logic [REG_W-1:0] lane_bits(input logic [REG_W/8-1:0] be);
    logic [REG_W-1:0] m;
    for (int b = 0; b < REG_W/8; b++) begin
      m[b*8 +: 8] = {8{be[b]}};
    end
    return m;
  endfunction

endpackage

// File: rtl/intx_rst_sync.sv
module intx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/intx_pend_bank.sv
module intx_pend_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic pend_d;
    logic pend_q;

    always_comb begin
      pend_d = lvl[i] | (pend_q & ~ack[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end

    assign pend[i] = pend_q;

    AST_LINE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[i] |=> pend[i]); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl[i] && !pend[i]) |=> !pend[i]); // R2
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !lvl[i]) |=> !pend[i]); // R3
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && lvl[i]) |=> pend[i]); // R4
  end
endmodule

// File: rtl/intx_err_flags.sv
module intx_err_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_q;

  always_comb begin
    flag_d = evt | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  for (genvar k = 0; k < N; k++) begin : g_chk
    AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[k] |=> flag[k]); // R6
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !evt[k]) |=> !flag[k]); // R6
  end
endmodule

// File: rtl/intx_ctrl_regs.sv
module intx_ctrl_regs
  import intx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  input  logic [REG_W-1:0]   wbits,
  output logic [N_LINES-1:0] line_ena,
  output logic [N_ERRS-1:0]  err_ena,
  output logic [PRIO_W-1:0]  prio
);
  logic [N_LINES-1:0] ena_q, ena_d;
  logic [N_ERRS-1:0]  een_q, een_d;
  logic [PRIO_W-1:0]  prio_q, prio_d;

  always_comb begin
    ena_d  = ena_q;
    een_d  = een_q;
    prio_d = prio_q;
    if (wr_en) begin
      for (int i = 0; i < N_LINES; i++) begin
        if (wbits[ENA_LSB+i]) ena_d[i] = wdata[ENA_LSB+i];
      end
      for (int k = 0; k < N_ERRS; k++) begin
        if (wbits[err_en_pos(k)]) een_d[k] = wdata[err_en_pos(k)];
      end
      for (int p = 0; p < PRIO_W; p++) begin
        if (wbits[PRIO_LSB+p]) prio_d[p] = wdata[PRIO_LSB+p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      een_q  <= '0;
      prio_q <= '0;
    end else if (wr_en) begin
      ena_q  <= ena_d;
      een_q  <= een_d;
      prio_q <= prio_d;
    end
  end

  assign line_ena = ena_q;
  assign err_ena  = een_q;
  assign prio     = prio_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(line_ena) && $stable(err_ena) && $stable(prio))); // R9
endmodule

// File: rtl/intx_irq_unit.sv
module intx_irq_unit
  import intx_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h4C,
  parameter logic [ADDR_W-1:0] FLAG_OFS = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        intx_lvl,
  input  logic [7:0]        err_evt,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  logic                rst_n_s;
  logic [REG_W-1:0]    wbits;
  logic                ctrl_wr;
  logic                flag_wr;
  logic [N_LINES-1:0]  ack;
  logic [N_ERRS-1:0]   fclr;
  logic [N_LINES-1:0]  pend;
  logic [N_LINES-1:0]  line_ena;
  logic [N_ERRS-1:0]   flag;
  logic [N_ERRS-1:0]   err_ena;
  logic [PRIO_W-1:0]   prio;
  logic [REG_W-1:0]    ctrl_word;
  logic                irq_d;
  logic                irq_q;

  intx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    wbits   = lane_bits(reg_be);
    ctrl_wr = reg_wr && (reg_addr == CTRL_OFS);
    flag_wr = reg_wr && (reg_addr == FLAG_OFS);
    ack     = ctrl_wr ? (reg_wdata[PEND_LSB +: N_LINES] & wbits[PEND_LSB +: N_LINES]) : '0;
    fclr    = flag_wr ? (reg_wdata[N_ERRS-1:0] & wbits[N_ERRS-1:0]) : '0;
  end

  intx_pend_bank #(.N(N_LINES)) u_pend (
    .clk   (clk),
    .rst_n (rst_n_s),
    .lvl   (intx_lvl),
    .ack   (ack),
    .pend  (pend)
  );

  intx_err_flags #(.N(N_ERRS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n_s),
    .evt   (err_evt),
    .clr   (fclr),
    .flag  (flag)
  );

  intx_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (ctrl_wr),
    .wdata    (reg_wdata),
    .wbits    (wbits),
    .line_ena (line_ena),
    .err_ena  (err_ena),
    .prio     (prio)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[PEND_LSB +: N_LINES] = pend;
    ctrl_word[ENA_LSB  +: N_LINES] = line_ena;
    for (int k = 0; k < N_ERRS; k++) begin
      ctrl_word[err_en_pos(k)] = err_ena[k];
    end
    ctrl_word[PRIO_LSB +: PRIO_W] = prio;
  end

  always_comb begin
    if (reg_addr == CTRL_OFS)      reg_rdata = ctrl_word;
    else if (reg_addr == FLAG_OFS) reg_rdata = {{(REG_W-N_ERRS){1'b0}}, flag};
    else                           reg_rdata = '0;
  end

  always_comb begin
    irq_d = (|(pend & line_ena)) | (|(flag & err_ena));
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign irq_out = irq_q;

  AST_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|(pend & line_ena)) |=> irq_out); // R5
  AST_IRQ_ERR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|(flag & err_ena)) |=> irq_out); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!(|(pend & line_ena)) && !(|(flag & err_ena))) |=> !irq_out); // R5
endmodule

// File: tb/intx_irq_unit_bench.sv
module intx_irq_unit_bench;
  localparam logic [7:0] CTRL = 8'h4C;
  localparam logic [7:0] FLGS = 8'h60;

  logic        clk;
  logic        rst_n;
  logic [3:0]  intx_lvl;
  logic [7:0]  err_evt;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [3:0] m_pend, m_ena;
  logic [7:0] m_flag, m_een;
  logic [6:0] m_prio;
  logic       m_irq;

  intx_irq_unit u_intx_irq_unit (
    .clk(clk), .rst_n(rst_n), .intx_lvl(intx_lvl), .err_evt(err_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] lanes(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic int een_bit(input int k);
    return (k < 6) ? 16 + k : 20 + k;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] w = '0;
    w[31:28] = m_pend;
    w[25:22] = m_ena;
    for (int k = 0; k < 8; k++) w[een_bit(k)] = m_een[k];
    w[14:8] = m_prio;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    reg_addr = CTRL; #1;
    chk({tag, " ctrl"}, reg_rdata, exp_ctrl());
    reg_addr = FLGS; #1;
    chk({tag, " flags"}, reg_rdata, {24'h0, m_flag});
    chk({tag, " irq"}, {31'h0, irq_out}, {31'h0, m_irq});
  endtask

  task automatic step(input string tag, input logic [3:0] lvl, input logic [7:0] evt,
                      input logic wr, input logic [7:0] addr, input logic [3:0] be,
                      input logic [31:0] data);
    logic [31:0] wm;
    logic [3:0]  n_pend, n_ena, ackv;
    logic [7:0]  n_flag, n_een, fclr;
    logic [6:0]  n_prio;
    logic        n_irq;
    @(negedge clk);
    intx_lvl = lvl; err_evt = evt; reg_wr = wr; reg_addr = addr;
    reg_be = be; reg_wdata = data;
    wm     = lanes(be);
    n_irq  = (|(m_pend & m_ena)) || (|(m_flag & m_een));
    ackv   = (wr && addr == CTRL) ? (data[31:28] & wm[31:28]) : 4'h0;
    fclr   = (wr && addr == FLGS) ? (data[7:0] & wm[7:0]) : 8'h0;
    n_pend = lvl | (m_pend & ~ackv);
    n_flag = evt | (m_flag & ~fclr);
    n_ena = m_ena; n_een = m_een; n_prio = m_prio;
    if (wr && addr == CTRL) begin
      for (int i = 0; i < 4; i++) if (wm[22+i]) n_ena[i] = data[22+i];
      for (int k = 0; k < 8; k++) if (wm[een_bit(k)]) n_een[k] = data[een_bit(k)];
      for (int p = 0; p < 7; p++) if (wm[8+p]) n_prio[p] = data[8+p];
    end
    @(posedge clk); #1;
    reg_wr = 1'b0; err_evt = 8'h0;
    m_pend = n_pend; m_flag = n_flag; m_ena = n_ena; m_een = n_een;
    m_prio = n_prio; m_irq = n_irq;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, intx_lvl, 8'h0, 1'b0, CTRL, 4'h0, 32'h0);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1C4A7);
    rst_n = 1'b0; intx_lvl = 4'h0; err_evt = 8'h0; reg_addr = CTRL;
    reg_wr = 1'b0; reg_be = 4'h0; reg_wdata = 32'h0;
    m_pend = 0; m_ena = 0; m_flag = 0; m_een = 0; m_prio = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    reg_addr = 8'h10; #1;
    chk("R8 unmapped offset", reg_rdata, 32'h0);

    // R2: line B high, disabled, still pending; irq stays low
    step("R2 capture", 4'b0010, 8'h0, 1'b0, CTRL, 4'h0, 32'h0);
    // R4: ack while line still high keeps it
    step("R4 ack under level", 4'b0010, 8'h0, 1'b1, CTRL, 4'hF, 32'h2000_0000);
    // R3: drop line, write zeros to pending field: no change
    step("R3 write zero", 4'b0000, 8'h0, 1'b1, CTRL, 4'hF, 32'h0000_0000);
    step("R3 ack", 4'b0000, 8'h0, 1'b1, CTRL, 4'hF, 32'h2000_0000);
    // R5: enable all lines, raise line C
    step("R5 enable", 4'b0000, 8'h0, 1'b1, CTRL, 4'hF, 32'h03C0_0000);
    step("R5 line C", 4'b0100, 8'h0, 1'b0, CTRL, 4'h0, 32'h0);
    idle("R5 irq high");
    step("R5 drop and ack", 4'b0000, 8'h0, 1'b1, CTRL, 4'hF, 32'h43C0_0000);
    idle("R5 irq low");
    // R6: sticky error flag, clear racing with new pulse
    step("R6 pulse", 4'b0000, 8'h08, 1'b0, CTRL, 4'h0, 32'h0);
    idle("R6 held");
    step("R6 clear vs pulse", 4'b0000, 8'h08, 1'b1, FLGS, 4'h1, 32'h0000_0008);
    step("R6 clear", 4'b0000, 8'h00, 1'b1, FLGS, 4'h1, 32'h0000_00FF);
    // R7: enable event 7 (bit 27) and event 2 (bit 18)
    step("R7 enable", 4'b0000, 8'h84, 1'b1, CTRL, 4'hF, 32'h0804_0000);
    idle("R7 irq");
    step("R7 clear", 4'b0000, 8'h00, 1'b1, FLGS, 4'h1, 32'h0000_0084);
    idle("R7 quiet");
    // R8: priority bits only, reserved bits read zero
    step("R8 prio", 4'b0000, 8'h0, 1'b1, CTRL, 4'b0011, 32'hFFFF_FFFF);
    step("R8 flag reserved", 4'b0000, 8'h0, 1'b1, FLGS, 4'hF, 32'hFFFF_FF00);
    // R9: lane masking, then halfword mask-and-clear
    step("R9 lane 0 only", 4'b0000, 8'h0, 1'b1, CTRL, 4'b0001, 32'hFFFF_FFFF);
    step("R9 setup", 4'b1111, 8'hFF, 1'b1, CTRL, 4'hF, 32'h0FFF_0000);
    step("R9 halfword", 4'b0000, 8'h0, 1'b1, CTRL, 4'b1100, 32'hF000_0000);
    idle("R9 after");

    for (int n = 0; n < 600; n++) begin
      logic [3:0]  lv;
      logic [7:0]  ev;
      logic [7:0]  ad;
      logic        w;
      lv = ($urandom % 4 == 0) ? 4'($urandom) : intx_lvl;
      ev = ($urandom % 3 == 0) ? 8'($urandom) : 8'h0;
      w  = ($urandom % 2 == 0);
      case ($urandom % 5)
        0, 1, 2: ad = CTRL;
        3:       ad = FLGS;
        default: ad = 8'($urandom);
      endcase
      step("R9 random", lv, ev, w, ad, 4'($urandom), $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule